// File: doc/BRIEF.md
# Timer Input Capture Unit

The block takes a snapshot of a free-running counter whenever a chosen trigger signal rises. The trigger comes from one of two places, picked by a select input: a dedicated capture pin or an internal comparator output. The chosen signal passes through a synchroniser. A two-state edge machine then turns each rising level into exactly one capture event. On that event the counter value is stored and a capture-pending flag is set. The stored value is also driven out continuously, so the counter logic can use it as its TOP value.

A processor reads the captured word over an 8-bit register bus, one byte at a time. Reading the low byte also copies the high byte into a temporary byte latch. A later high-byte read returns that latch, so the two halves always belong to one capture. The latch is shared with the other wide registers of the timer. A neighbouring register can load it through a side port.

The block also holds an interrupt-mask register with four enables. Each interrupt request is the AND of its enable, a global interrupt enable and the matching pending flag.

Edge machine states and transitions:
- `TRIG_LOW` → `TRIG_HIGH` when the synchronised trigger is 1. This transition is the capture event.
- `TRIG_HIGH` → `TRIG_LOW` when the synchronised trigger is 0.
- Each state stays put otherwise.

Register addresses (`bus_addr`):
- 0: capture low byte
- 1: capture high byte, read through the latch
- 2: mask register
- 3: flag register

Top module: `icap_unit`

## Requirements
- R1: On a capture event, the capture register loads `cnt_val`. A trigger that goes high just after a falling clock edge is captured at the third rising clock edge that follows. Outside events the capture register holds its value.
- R2: `src_sel`=0 selects `trig_pin` and `src_sel`=1 selects `trig_cmp`. Edges on the unselected input cause no capture.
- R3: `top_val` always shows the capture register.
- R4: A read of address 0 returns capture bits [7:0] in the same cycle and loads capture bits [15:8] into the temporary latch. A read of address 1 returns the latch.
- R5: A pulse on `ext_tmp_ld` loads `ext_tmp_val` into the shared latch, which a later address 1 read returns. A CPU low-byte read in the same cycle takes priority.
- R6: Mask register at address 2: bit 5 enables capture, bit 2 enables compare B, bit 1 enables compare A and bit 0 enables overflow. The bits are read/write.
- R7: Mask bits 7, 6, 4 and 3 read as 0 and ignore writes.
- R8: Each of `irq_cap`, `irq_cmpb`, `irq_cmpa` and `irq_ovf` is 1 exactly when its mask bit, `gie` and its pending flag are all 1.
- R9: A capture event sets the capture-pending flag, which reads as bit 5 of address 3. Writing 1 to that bit clears the flag and writing 0 leaves it unchanged. A capture in the same cycle as a clear leaves the flag set.
- R10: If a low-byte read falls in the capture cycle, the read returns the old low byte and the latch gets the old high byte. The new value appears afterwards.
- R11: A trigger held high yields exactly one capture; the edge machine never reports events in two consecutive cycles.
- R12: After reset the capture register, latch, mask register and pending flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | 16 | Current counter value |
| trig_pin | input | 1 | Capture pin trigger |
| trig_cmp | input | 1 | Comparator trigger |
| src_sel | input | 1 | Trigger source select (1 = comparator) |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle, 0 when idle |
| ext_tmp_ld | input | 1 | Latch load from another wide register |
| ext_tmp_val | input | 8 | Byte for that load |
| gie | input | 1 | Global interrupt enable |
| cmpa_pend | input | 1 | Compare A pending flag |
| cmpb_pend | input | 1 | Compare B pending flag |
| ovf_pend | input | 1 | Overflow pending flag |
| top_val | output | 16 | Captured value for use as TOP |
| irq_ovf | output | 1 | Overflow request |
| irq_cmpa | output | 1 | Compare A request |
| irq_cmpb | output | 1 | Compare B request |
| irq_cap | output | 1 | Capture request |

## Verification
Several properties are checked on every cycle:
- an event loads the counter value and sets the pending flag;
- events never fall in back-to-back cycles;
- a low-byte read or a side load fills the latch;
- the unused mask bits stay 0;
- a request is never raised without its enable, `gie` and its pending flag.

Other behaviours can only be shown by the bench's scenarios:
- the three-edge capture latency;
- that the unselected source is ignored;
- the write-one-to-clear rule with set winning over clear;
- that a read colliding with a capture still returns the old bytes.

// File: rtl/icap_pkg.sv
package icap_pkg;
    typedef enum logic [1:0] {
        ADR_CAP_LO = 2'd0,
        ADR_CAP_HI = 2'd1,
        ADR_MASK   = 2'd2,
        ADR_FLAG   = 2'd3
    } icap_addr_e;

    typedef enum logic {
        TRIG_LOW  = 1'b0,
        TRIG_HIGH = 1'b1
    } trig_state_e;

    // Bit positions inside the mask and flag registers
    localparam int BIT_OVF  = 0;
    localparam int BIT_CMPA = 1;
    localparam int BIT_CMPB = 2;
    localparam int BIT_CAP  = 5;
    localparam int NSRC     = 4;
    // Source index i -> mask bit; order: ovf, cmpa, cmpb, cap
    localparam int SRC_POS [NSRC] = '{BIT_OVF, BIT_CMPA, BIT_CMPB, BIT_CAP};
    localparam logic [7:0] MASK_RW = 8'b0010_0111;
endpackage

// File: rtl/icap_edge_fsm.sv
module icap_edge_fsm
    import icap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_raw,
    output logic evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    trig_state_e            state_q;
    trig_state_e            state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], trig_raw};
    end

    assign lvl = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRIG_LOW;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRIG_LOW:  if (lvl)  state_d = TRIG_HIGH;
            TRIG_HIGH: if (!lvl) state_d = TRIG_LOW;
        endcase
    end

    // Outputs
    always_comb begin
        evt = 1'b0;
        unique case (state_q)
            TRIG_LOW:  evt = lvl;
            TRIG_HIGH: evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/icap_temp_latch.sv
module icap_temp_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpu_ld,
    input  logic [W-1:0] cpu_val,
    input  logic         ext_ld,
    input  logic [W-1:0] ext_val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (cpu_ld) q <= cpu_val;
        else if (ext_ld) q <= ext_val;
    end
endmodule

// File: rtl/icap_irq_mask.sv
module icap_irq_mask
    import icap_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    input  logic             gie,
    input  logic [NSRC-1:0]  pend,
    output logic [BUS_W-1:0] mask_q,
    output logic [NSRC-1:0]  irq
);
    localparam logic [BUS_W-1:0] RW_BITS = BUS_W'(MASK_RW);

    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wdata & RW_BITS;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign irq[i] = mask_q[SRC_POS[i]] & gie & pend[i];
    end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             trig_pin,
    input  logic             trig_cmp,
    input  logic             src_sel,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             ext_tmp_ld,
    input  logic [BUS_W-1:0] ext_tmp_val,
    input  logic             gie,
    input  logic             cmpa_pend,
    input  logic             cmpb_pend,
    input  logic             ovf_pend,
    output logic [CNT_W-1:0] top_val,
    output logic             irq_ovf,
    output logic             irq_cmpa,
    output logic             irq_cmpb,
    output logic             irq_cap
);
    localparam int HI_W = CNT_W - BUS_W;

    icap_addr_e       addr_e;
    logic             trig_sel;
    logic             evt;
    logic [CNT_W-1:0] cap_q;
    logic [BUS_W-1:0] tmp_q;
    logic [BUS_W-1:0] mask_q;
    logic             cap_pend_q;
    logic             lo_rd;
    logic             flag_clr;
    logic [NSRC-1:0]  pend_vec;
    logic [NSRC-1:0]  irq_vec;

    assign addr_e   = icap_addr_e'(bus_addr);
    assign trig_sel = src_sel ? trig_cmp : trig_pin;
    assign lo_rd    = bus_rd && (addr_e == ADR_CAP_LO);
    assign flag_clr = bus_wr && (addr_e == ADR_FLAG) && bus_wdata[BIT_CAP];

    icap_edge_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_raw (trig_sel),
        .evt      (evt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)   cap_q <= '0;
        else if (evt) cap_q <= cnt_val;
    end

    // Capture sets the flag; set has priority over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_pend_q <= 1'b0;
        else if (evt)      cap_pend_q <= 1'b1;
        else if (flag_clr) cap_pend_q <= 1'b0;
    end

    icap_temp_latch #(.W(BUS_W)) u_tmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_ld  (lo_rd),
        .cpu_val (BUS_W'(cap_q[CNT_W-1:CNT_W-HI_W])),
        .ext_ld  (ext_tmp_ld),
        .ext_val (ext_tmp_val),
        .q       (tmp_q)
    );

    assign pend_vec = {cap_pend_q, cmpb_pend, cmpa_pend, ovf_pend};

    icap_irq_mask #(.BUS_W(BUS_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr && (addr_e == ADR_MASK)),
        .wdata  (bus_wdata),
        .gie    (gie),
        .pend   (pend_vec),
        .mask_q (mask_q),
        .irq    (irq_vec)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (addr_e)
                ADR_CAP_LO: bus_rdata = cap_q[BUS_W-1:0];
                ADR_CAP_HI: bus_rdata = tmp_q;
                ADR_MASK:   bus_rdata = mask_q;
                ADR_FLAG:   bus_rdata[BIT_CAP] = cap_pend_q;
            endcase
        end
    end

    assign top_val  = cap_q;
    assign irq_ovf  = irq_vec[0];
    assign irq_cmpa = irq_vec[1];
    assign irq_cmpb = irq_vec[2];
    assign irq_cap  = irq_vec[3];
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk
    import icap_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] top_val,
    input logic [CNT_W-1:0] cap_q,
    input logic [BUS_W-1:0] tmp_q,
    input logic [BUS_W-1:0] mask_q,
    input logic             cap_pend_q,
    input logic             bus_rd,
    input logic [1:0]       bus_addr,
    input logic             ext_tmp_ld,
    input logic [BUS_W-1:0] ext_tmp_val,
    input logic             gie,
    input logic             cmpa_pend,
    input logic             cmpb_pend,
    input logic             ovf_pend,
    input logic             irq_ovf,
    input logic             irq_cmpa,
    input logic             irq_cmpb,
    input logic             irq_cap
);
    logic lo_rd;
    assign lo_rd = bus_rd && (bus_addr == ADR_CAP_LO);

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> top_val == $past(cnt_val));
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(cap_q));
    assert_lo_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> tmp_q == $past(cap_q[CNT_W-1:CNT_W-BUS_W]));
    assert_ext_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_tmp_ld && !lo_rd) |=> tmp_q == $past(ext_tmp_val));
    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask_q & ~BUS_W'(MASK_RW)) == 0);
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cap  |-> (gie && cap_pend_q && mask_q[BIT_CAP]))  and
        (irq_cmpb |-> (gie && cmpb_pend  && mask_q[BIT_CMPB])) and
        (irq_cmpa |-> (gie && cmpa_pend  && mask_q[BIT_CMPA])) and
        (irq_ovf  |-> (gie && ovf_pend   && mask_q[BIT_OVF])));
    assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> cap_pend_q);
    assert_single_evt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt         (evt),
    .cnt_val     (cnt_val),
    .top_val     (top_val),
    .cap_q       (cap_q),
    .tmp_q       (tmp_q),
    .mask_q      (mask_q),
    .cap_pend_q  (cap_pend_q),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .ext_tmp_ld  (ext_tmp_ld),
    .ext_tmp_val (ext_tmp_val),
    .gie         (gie),
    .cmpa_pend   (cmpa_pend),
    .cmpb_pend   (cmpb_pend),
    .ovf_pend    (ovf_pend),
    .irq_ovf     (irq_ovf),
    .irq_cmpa    (irq_cmpa),
    .irq_cmpb    (irq_cmpb),
    .irq_cap     (irq_cap)
);

// File: tb/tb_icap_unit.sv
module tb_icap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        trig_pin = 1'b0, trig_cmp = 1'b0, src_sel = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic        ext_tmp_ld = 1'b0;
    logic [7:0]  ext_tmp_val = '0;
    logic        gie = 1'b0, cmpa_pend = 1'b0, cmpb_pend = 1'b0, ovf_pend = 1'b0;
    logic [15:0] top_val;
    logic        irq_ovf, irq_cmpa, irq_cmpb, irq_cap;

    int tests = 0;
    int fails = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    icap_unit dut (.*);

    // {mask[7:0], gie, pa, pb, po, ea, eb, eo}
    localparam logic [14:0] VEC [8] = '{
        {8'h27, 1'b1, 3'b111, 3'b111},
        {8'h27, 1'b0, 3'b111, 3'b000},
        {8'h02, 1'b1, 3'b111, 3'b100},
        {8'h04, 1'b1, 3'b111, 3'b010},
        {8'h01, 1'b1, 3'b111, 3'b001},
        {8'h27, 1'b1, 3'b010, 3'b010},
        {8'hFF, 1'b1, 3'b101, 3'b101},
        {8'h00, 1'b1, 3'b111, 3'b000}
    };

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] e;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R12 reset state
        check(top_val == 16'h0, "R12 capture reset", top_val, 16'h0);
        rd(2'd0, d); check(d == 8'h00, "R12 low byte reset", {8'h0, d}, 16'h0);
        rd(2'd1, d); check(d == 8'h00, "R12 latch reset", {8'h0, d}, 16'h0);
        rd(2'd2, d); check(d == 8'h00, "R12 mask reset", {8'h0, d}, 16'h0);
        rd(2'd3, d); check(d == 8'h00, "R12 flag reset", {8'h0, d}, 16'h0);

        // R6 R7 R8 vector table
        for (int i = 0; i < 8; i++) begin
            wr(2'd2, VEC[i][14:7]);
            @(negedge clk);
            gie = VEC[i][6]; cmpa_pend = VEC[i][5]; cmpb_pend = VEC[i][4]; ovf_pend = VEC[i][3];
            #1;
            check({irq_cmpa, irq_cmpb, irq_ovf} == VEC[i][2:0], "R8 irq gating",
                  {13'h0, irq_cmpa, irq_cmpb, irq_ovf}, {13'h0, VEC[i][2:0]});
            check(irq_cap == 1'b0, "R8 capture irq idle", {15'h0, irq_cap}, 16'h0);
            e = VEC[i][14:7] & 8'h27;
            rd(2'd2, d); check(d == e, "R6 R7 mask readback", {8'h0, d}, {8'h0, e});
        end
        gie = 1'b0; cmpa_pend = 1'b0; cmpb_pend = 1'b0; ovf_pend = 1'b0;

        // R7 unused bits only
        wr(2'd2, 8'hD8);
        rd(2'd2, d); check(d == 8'h00, "R7 unused bits ignored", {8'h0, d}, 16'h0);

        // R1 R3 capture from pin
        cnt_val = 16'hA5C3;
        @(negedge clk); trig_pin = 1'b1;
        idle(2);
        check(top_val == 16'h0000, "R1 no capture before third edge", top_val, 16'h0);
        idle(1);
        check(top_val == 16'hA5C3, "R1 R3 captured value", top_val, 16'hA5C3);
        // R11 held high
        cnt_val = 16'h1111;
        idle(6);
        check(top_val == 16'hA5C3, "R11 single capture while held", top_val, 16'hA5C3);
        trig_pin = 1'b0;
        idle(3);

        // R9 flag and R8 capture irq
        rd(2'd3, d); check(d == 8'h20, "R9 flag set", {8'h0, d}, 16'h20);
        wr(2'd2, 8'h20);
        @(negedge clk); gie = 1'b1; #1;
        check(irq_cap == 1'b1, "R8 capture irq", {15'h0, irq_cap}, 16'h1);
        gie = 1'b0;
        wr(2'd3, 8'h00);
        rd(2'd3, d); check(d == 8'h20, "R9 write zero keeps flag", {8'h0, d}, 16'h20);
        wr(2'd3, 8'h20);
        rd(2'd3, d); check(d == 8'h00, "R9 write one clears", {8'h0, d}, 16'h0);

        // R4 byte reads
        rd(2'd0, d); check(d == 8'hC3, "R4 low byte", {8'h0, d}, 16'hC3);
        rd(2'd1, d); check(d == 8'hA5, "R4 high byte via latch", {8'h0, d}, 16'hA5);

        // R5 shared latch side load
        @(negedge clk); ext_tmp_ld = 1'b1; ext_tmp_val = 8'h5E;
        @(negedge clk); ext_tmp_ld = 1'b0;
        rd(2'd1, d); check(d == 8'h5E, "R5 side load", {8'h0, d}, 16'h5E);
        // R5 CPU low read wins over same-cycle side load
        @(negedge clk); bus_rd = 1'b1; bus_addr = 2'd0; ext_tmp_ld = 1'b1; ext_tmp_val = 8'h99;
        @(negedge clk); bus_rd = 1'b0; ext_tmp_ld = 1'b0;
        rd(2'd1, d); check(d == 8'hA5, "R5 CPU read priority", {8'h0, d}, 16'hA5);

        // R2 source select
        cnt_val = 16'h2222;
        @(negedge clk); trig_cmp = 1'b1;
        idle(5);
        check(top_val == 16'hA5C3, "R2 comparator ignored", top_val, 16'hA5C3);
        trig_cmp = 1'b0;
        idle(3);
        src_sel = 1'b1;
        idle(3);
        @(negedge clk); trig_pin = 1'b1;
        idle(5);
        check(top_val == 16'hA5C3, "R2 pin ignored", top_val, 16'hA5C3);
        trig_pin = 1'b0;
        idle(3);
        @(negedge clk); trig_cmp = 1'b1;
        idle(4);
        check(top_val == 16'h2222, "R2 comparator capture", top_val, 16'h2222);
        trig_cmp = 1'b0; src_sel = 1'b0;
        idle(4);

        // R10 read colliding with capture
        cnt_val = 16'h7E81;
        @(negedge clk); trig_pin = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_rd = 1'b1; bus_addr = 2'd0; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
        check(d == 8'h22, "R10 old low byte", {8'h0, d}, 16'h22);
        rd(2'd1, d); check(d == 8'h22, "R10 old high byte", {8'h0, d}, 16'h22);
        check(top_val == 16'h7E81, "R10 new capture", top_val, 16'h7E81);
        rd(2'd0, d); check(d == 8'h81, "R10 new low byte", {8'h0, d}, 16'h81);
        rd(2'd1, d); check(d == 8'h7E, "R10 new high byte", {8'h0, d}, 16'h7E);
        trig_pin = 1'b0;
        idle(3);

        // R9 set wins over clear in the same cycle
        wr(2'd3, 8'h20);
        rd(2'd3, d); check(d == 8'h00, "R9 cleared before collision", {8'h0, d}, 16'h0);
        cnt_val = 16'h0F0F;
        @(negedge clk); trig_pin = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h20;
        @(negedge clk); bus_wr = 1'b0;
        rd(2'd3, d); check(d == 8'h20, "R9 set beats clear", {8'h0, d}, 16'h20);
        check(top_val == 16'h0F0F, "R1 capture during clear", top_val, 16'h0F0F);
        trig_pin = 1'b0;
        idle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule